// File: doc/BRIEF.md
# Sample-Clocked Converter Streaming Controller

This block sits between a host bus and three data converters: one DAC output and two ADC inputs. All three share a single sample enable. A sample tick happens on each clock cycle where the run line and the sample enable are both high. On each tick, one word leaves the outbound (DAC) queue and goes to the DAC output register. In the same tick, the two ADC lanes are packed into one word and enter the inbound (ADC) queue. Between bursts, the host fills the outbound queue and empties the inbound queue.

A block timer runs on the same sample ticks. It raises a one-cycle interrupt after every programmed number of ticks, so the host can service both queues in fixed-size blocks. Four sticky flags record starvation and loss on either queue. The host clears them with a write-one-to-clear mask. Before raising run, the host is expected to preload the outbound queue; raising run while that queue is empty starves the DAC at once.

Top module: `adc_dac_stream_ctrl`

## Requirements
- R1: After reset, `dac_data`, `irq` and `status` are zero, both queues are empty and the block timer period is 256 ticks.
- R2: On each tick (`run` and `smp_en` high), the oldest outbound word is loaded into `dac_data`, visible from the next cycle. Words appear in the order the host wrote them.
- R3: On each tick, the word {lane 1, lane 0} is stored in the inbound queue, with lane 0 at `adc_samples[11:0]` and lane 1 at `adc_samples[23:12]`. `adc_rd_data` shows the oldest stored word in the same cycle, and `adc_rd_en` removes that word at the clock edge.
- R4: Without a tick, `dac_data` holds its value and no inbound word is stored.
- R5: A tick while the outbound queue is empty sets `status[2]` and leaves `dac_data` unchanged.
- R6: A host write while the outbound queue holds 512 words sets `status[3]` and the word is discarded. Fullness is judged before any pop in the same cycle.
- R7: A host read while the inbound queue is empty sets `status[0]` and returns zero on `adc_rd_data`. Emptiness is judged before any push in the same cycle.
- R8: A tick while the inbound queue holds 512 words sets `status[1]` and that sample is discarded.
- R9: Status flags stay set until a `clr_en` cycle whose `clr_mask` has a one at that bit. If the flag's event occurs in the same cycle as its clear, the flag stays set.
- R10: `irq` is high for exactly the one cycle after every Nth tick, where N is the programmed period. A period of 0 behaves like 1.
- R11: While `run` is low, the timer reloads the full period. A newly written period takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Conversion enable for both paths |
| smp_en | input | 1 | Shared sample enable |
| adc_samples | input | 24 | Two 12-bit ADC lanes, lane 0 in low bits |
| dac_wr_en | input | 1 | Host write to outbound queue |
| dac_wr_data | input | 12 | Host write data |
| adc_rd_en | input | 1 | Host read of inbound queue |
| adc_rd_data | output | 24 | Oldest inbound word, zero when empty |
| dac_data | output | 12 | DAC output register |
| preset_we | input | 1 | Block timer period write |
| preset_d | input | 16 | Block timer period value |
| irq | output | 1 | One-cycle block interrupt |
| clr_en | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Write-one-to-clear mask |
| status | output | 4 | [0] inbound underflow, [1] inbound overflow, [2] outbound underflow, [3] outbound overflow |

## Verification
Two collisions are provoked on purpose, each by driving both inputs in the same cycle. In the first, the host writes to a full outbound queue in the same cycle as a tick pops from it. The bench's queue model discards that write and expects `status[3]` to be set; the full drain that follows must then show every accepted word in order, with the dropped one missing. In the second, the same pairing happens on a status bit: an outbound starve falls in the same cycle as a clear of `status[2]`. The model expects the bit to remain set, and it also tracks timer interrupts that coincide with underflow ticks.

// File: rtl/stream_pkg.sv
package stream_pkg;
  localparam int ST_W      = 4;
  localparam int ST_ADC_UF = 0;
  localparam int ST_ADC_OF = 1;
  localparam int ST_DAC_UF = 2;
  localparam int ST_DAC_OF = 3;

  typedef logic [ST_W-1:0] status_t;

  // Sticky flag update: new events win over a clear in the same cycle.
  function automatic status_t status_next(input status_t cur, input status_t evt,
                                          input logic clr, input status_t mask);
    status_t keep;
    keep = clr ? (cur & ~mask) : cur;
    return keep | evt;
  endfunction

  // Terminal count: a count of 0 or 1 ends the block on this tick.
  function automatic logic block_done(input logic [15:0] cnt);
    return (cnt <= 16'd1);
  endfunction
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 512,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      level <= level + LW'(push) - LW'(pop);
    end
  end
endmodule

// File: rtl/block_timer.sv
module block_timer #(
  parameter int CNT_W       = 16,
  parameter int RST_PERIOD  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             preset_we,
  input  logic [CNT_W-1:0] preset_d,
  output logic             irq,
  output logic             hit
);
  logic [CNT_W-1:0] preset_q, cnt;

  assign hit = tick && stream_pkg::block_done(16'(cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset_q <= CNT_W'(RST_PERIOD);
      cnt      <= CNT_W'(RST_PERIOD);
      irq      <= 1'b0;
    end else begin
      irq <= hit;
      if (preset_we) preset_q <= preset_d;
      if (!run)      cnt <= preset_q;
      else if (hit)  cnt <= preset_q;
      else if (tick) cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/adc_dac_stream_ctrl.sv
module adc_dac_stream_ctrl #(
  parameter int SMP_W      = 12,
  parameter int ADC_CH     = 2,
  parameter int DEPTH      = 512,
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 256,
  localparam int RD_W      = SMP_W * ADC_CH,
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        smp_en,
  input  logic [RD_W-1:0]             adc_samples,
  input  logic                        dac_wr_en,
  input  logic [SMP_W-1:0]            dac_wr_data,
  input  logic                        adc_rd_en,
  output logic [RD_W-1:0]             adc_rd_data,
  output logic [SMP_W-1:0]            dac_data,
  input  logic                        preset_we,
  input  logic [CNT_W-1:0]            preset_d,
  output logic                        irq,
  input  logic                        clr_en,
  input  logic [stream_pkg::ST_W-1:0] clr_mask,
  output logic [stream_pkg::ST_W-1:0] status
);
  import stream_pkg::*;

  logic tick;
  logic dac_empty, dac_full, adc_empty, adc_full;
  logic [SMP_W-1:0] dac_head;
  logic [RD_W-1:0]  adc_head, adc_word;
  logic [LW-1:0]    dac_level, adc_level;
  logic dac_pop, dac_push, adc_pop, adc_push;
  logic dac_starve, dac_reject, adc_drop, adc_starve;
  logic blk_hit;
  status_t evt;

  assign tick = run && smp_en;

  // Lane packing: lane i occupies its own SMP_W slice of the stored word.
  for (genvar i = 0; i < ADC_CH; i++) begin : g_lane
    assign adc_word[i*SMP_W +: SMP_W] = adc_samples[i*SMP_W +: SMP_W];
  end

  // Named events, judged on queue state before this cycle's updates.
  assign dac_pop    = tick && !dac_empty;
  assign dac_starve = tick &&  dac_empty;
  assign dac_push   = dac_wr_en && !dac_full;
  assign dac_reject = dac_wr_en &&  dac_full;
  assign adc_push   = tick && !adc_full;
  assign adc_drop   = tick &&  adc_full;
  assign adc_pop    = adc_rd_en && !adc_empty;
  assign adc_starve = adc_rd_en &&  adc_empty;

  sample_fifo #(.W(SMP_W), .DEPTH(DEPTH)) u_dac_q (
    .clk(clk), .rst_n(rst_n),
    .push(dac_push), .push_data(dac_wr_data),
    .pop(dac_pop), .head(dac_head),
    .empty(dac_empty), .full(dac_full), .level(dac_level)
  );

  sample_fifo #(.W(RD_W), .DEPTH(DEPTH)) u_adc_q (
    .clk(clk), .rst_n(rst_n),
    .push(adc_push), .push_data(adc_word),
    .pop(adc_pop), .head(adc_head),
    .empty(adc_empty), .full(adc_full), .level(adc_level)
  );

  block_timer #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .preset_we(preset_we), .preset_d(preset_d),
    .irq(irq), .hit(blk_hit)
  );

  assign adc_rd_data = adc_empty ? '0 : adc_head;

  always_comb begin
    evt            = '0;
    evt[ST_ADC_UF] = adc_starve;
    evt[ST_ADC_OF] = adc_drop;
    evt[ST_DAC_UF] = dac_starve;
    evt[ST_DAC_OF] = dac_reject;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_data <= '0;
      status   <= '0;
    end else begin
      if (dac_pop) dac_data <= dac_head;
      status <= status_next(status, evt, clr_en, clr_mask);
    end
  end
endmodule

// File: rtl/stream_ctrl_chk.sv
module stream_ctrl_chk #(
  parameter int SMP_W = 12,
  parameter int RD_W  = 24,
  parameter int DEPTH = 512,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             smp_en,
  input logic             irq,
  input logic [SMP_W-1:0] dac_data,
  input logic [3:0]       status,
  input logic             clr_en,
  input logic [3:0]       clr_mask,
  input logic             dac_starve,
  input logic             dac_reject,
  input logic             adc_drop,
  input logic             adc_starve,
  input logic [RD_W-1:0]  adc_rd_data,
  input logic [LW-1:0]    dac_level
);
  p_irq_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run && smp_en));

  p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(run && smp_en)) |-> $stable(dac_data));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
      ((($past(status) & ~($past(clr_en) ? $past(clr_mask) : 4'b0)) & ~status) == 4'b0));

  p_dac_starve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_starve |=> status[2]);

  p_dac_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_reject |=> status[3]);

  p_adc_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_drop |=> status[1]);

  p_adc_starve_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_starve |-> (adc_rd_data == '0) ##1 status[0]);

  p_no_overfill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_level <= LW'(DEPTH));
endmodule

bind adc_dac_stream_ctrl stream_ctrl_chk #(.SMP_W(SMP_W), .RD_W(RD_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .smp_en(smp_en), .irq(irq),
  .dac_data(dac_data), .status(status), .clr_en(clr_en), .clr_mask(clr_mask),
  .dac_starve(dac_starve), .dac_reject(dac_reject), .adc_drop(adc_drop),
  .adc_starve(adc_starve), .adc_rd_data(adc_rd_data), .dac_level(dac_level)
);

// File: tb/sim_adc_dac_stream_ctrl.sv
module sim_adc_dac_stream_ctrl;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, smp_en = 0, dac_wr_en = 0, adc_rd_en = 0;
  logic preset_we = 0, clr_en = 0;
  logic [23:0] adc_samples = '0;
  logic [11:0] dac_wr_data = '0;
  logic [15:0] preset_d = '0;
  logic [3:0]  clr_mask = '0;
  logic [23:0] adc_rd_data;
  logic [11:0] dac_data;
  logic        irq;
  logic [3:0]  status;

  always #4 clk = ~clk;

  adc_dac_stream_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .smp_en(smp_en),
    .adc_samples(adc_samples), .dac_wr_en(dac_wr_en), .dac_wr_data(dac_wr_data),
    .adc_rd_en(adc_rd_en), .adc_rd_data(adc_rd_data), .dac_data(dac_data),
    .preset_we(preset_we), .preset_d(preset_d), .irq(irq),
    .clr_en(clr_en), .clr_mask(clr_mask), .status(status)
  );

  int n_vec = 0, n_bad = 0, smp_no = 0;
  bit done = 0;

  // Scoreboard state
  logic [11:0] dq[$];
  logic [23:0] aq[$];
  logic [11:0] exp_dac = '0;
  logic [3:0]  exp_st = '0;
  int          cnt = 256, per = 256;
  logic        exp_irq = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] smp_val(input int k);
    return {12'(k * 7 + 3), 12'(k * 5 + 1)};
  endfunction

  // Driver: applies one cycle of stimulus, updates the model, monitor compares.
  task automatic step(input bit r, input bit se, input bit wr, input logic [11:0] wd,
                      input bit rd, input bit clr, input logic [3:0] mask,
                      input bit pw, input logic [15:0] pv);
    int dsz, asz;
    logic [3:0] evt;
    logic [23:0] samp;
    samp = smp_val(smp_no);
    run = r; smp_en = se; dac_wr_en = wr; dac_wr_data = wd; adc_rd_en = rd;
    clr_en = clr; clr_mask = mask; preset_we = pw; preset_d = pv; adc_samples = samp;
    #1;
    dsz = dq.size(); asz = aq.size(); evt = '0;
    if (rd) begin
      if (asz > 0) chk(adc_rd_data == aq[0], "R3 inbound order", adc_rd_data, aq[0]);
      else         chk(adc_rd_data == 24'h0, "R7 empty read data", adc_rd_data, 0);
    end
    if (wr) begin
      if (dsz < DEPTH) dq.push_back(wd); else evt[3] = 1;
    end
    if (r && se) begin
      if (dsz > 0) exp_dac = dq.pop_front(); else evt[2] = 1;
    end
    if (rd) begin
      if (asz > 0) void'(aq.pop_front()); else evt[0] = 1;
    end
    if (r && se) begin
      if (asz < DEPTH) aq.push_back(samp); else evt[1] = 1;
    end
    exp_st  = (clr ? (exp_st & ~mask) : exp_st) | evt;
    exp_irq = 0;
    if (!r) cnt = per;
    else if (se) begin
      if (cnt <= 1) begin exp_irq = 1; cnt = per; end
      else cnt--;
    end
    if (pw) per = pv;
    if (r && se) smp_no++;
    @(posedge clk); #1;
    chk(dac_data == exp_dac, "R2 dac output", dac_data, exp_dac);
    chk(irq == exp_irq, "R10 irq", irq, exp_irq);
    chk(status == exp_st, "R9 status", status, exp_st);
    run = 0; smp_en = 0; dac_wr_en = 0; adc_rd_en = 0; clr_en = 0; preset_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr_dac(input logic [11:0] d);
    step(0, 0, 1, d, 0, 0, 0, 0, 0);
  endtask
  task automatic ticks(input int n, input bit se_alt);
    for (int i = 0; i < n; i++) step(1, se_alt ? ((i % 2) == 0) : 1'b1, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rd_adc(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask
  task automatic clr_all();
    step(0, 0, 0, 0, 0, 1, 4'hF, 0, 0);
  endtask

  initial begin
    int irq_seen;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(posedge clk); #1;
    // R1: reset state
    chk(dac_data == 0 && irq == 0 && status == 0, "R1 reset outputs", {dac_data, irq, status}, 0);
    chk(adc_rd_data == 0, "R1 inbound empty", adc_rd_data, 0);
    // R1: default 256-tick period, then program 4
    for (int i = 0; i < 256; i++) wr_dac(12'(i + 100));
    irq_seen = 0;
    for (int i = 0; i < 256; i++) begin
      step(1, 1, 0, 0, 0, 0, 0, 0, 0);
      if (irq) irq_seen = i + 1;
    end
    chk(irq_seen == 256, "R1 default period", irq_seen, 256);
    rd_adc(256);
    chk(status == 0, "R3 all read back", status, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'd4);
    // R2/R10: eight words, period 4
    for (int i = 0; i < 8; i++) wr_dac(12'h0A0 + 12'(i));
    ticks(8, 0);
    // R5: starve
    ticks(1, 0);
    chk(status[2] == 1 && dac_data == 12'h0A7, "R5 starve holds", {status, dac_data}, {4'h4, 12'h0A7});
    // R3/R7
    rd_adc(9);
    rd_adc(1);
    chk(status[0] == 1, "R7 underflow flag", status, 4'h5);
    // R9 partial clear
    step(0, 0, 0, 0, 0, 1, 4'b0001, 0, 0);
    chk(status == 4'b0100, "R9 partial clear", status, 4'b0100);
    clr_all();
    // R4: gated sample enable
    for (int i = 0; i < 6; i++) wr_dac(12'h300 + 12'(i));
    ticks(12, 1);
    chk(dac_data == 12'h305, "R4 gated advance", dac_data, 12'h305);
    idle(3);
    rd_adc(6);
    // R11: run low reloads
    for (int i = 0; i < 8; i++) wr_dac(12'h400 + 12'(i));
    ticks(2, 0);
    idle(2);
    irq_seen = 0;
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 0, 0, 0, 0, 0, 0, 0);
      if (irq) irq_seen = i + 1;
    end
    chk(irq_seen == 4, "R11 reload after stop", irq_seen, 4);
    // R10: period 0 acts as 1
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'd0);
    idle(1);
    ticks(2, 0);
    chk(irq == 1, "R10 period zero", irq, 1);
    rd_adc(aq.size());
    clr_all();
    // R6: fill outbound queue, overflow
    for (int i = 0; i < DEPTH; i++) wr_dac(12'(i * 3));
    chk(status == 0, "R6 no flag at exactly full", status, 0);
    wr_dac(12'hFFF);
    chk(status[3] == 1, "R6 overflow flag", status, 4'h8);
    clr_all();
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'd64);
    // Collision: write to full queue during a pop
    step(1, 1, 1, 12'hEEE, 0, 0, 0, 0, 0);
    chk(status[3] == 1, "R6 collision write dropped", status, 4'h8);
    // Drain 511 remaining; inbound fills to 512 and then drops (R8)
    ticks(DEPTH - 1, 0);
    chk(status[3:1] == 3'b100, "R8 inbound not yet over", status, 4'h8);
    ticks(1, 0);
    chk(status[1] == 1 && status[2] == 1, "R8 inbound overflow", status, 4'hE);
    // R9: starve in same cycle as clear of that bit, set wins
    step(1, 1, 0, 0, 0, 1, 4'b0100, 0, 0);
    chk(status[2] == 1, "R9 set beats clear", status, 4'hE);
    rd_adc(DEPTH);
    chk(status[0] == 0, "R3 full drain no underflow", status, 4'hE);
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule